// File: doc/BRIEF.md
# Event-Placed Pin Waveform Formatter

This block is the timing heart of one tester channel. A programmable prescaler turns the system clock into a base timing tick. Eight stored cycle definitions each give a cycle length in ticks and eight event positions inside the cycle. For every test vector the block takes a cycle-definition number, one drive data bit, a format code and four event selections. The event selections mark where the drive span starts and ends and where the compare window opens and closes. From these it produces the pin drive level, the drive enable (low means the pin is released to high impedance) and the compare-strobe window.

A vector source feeds the block through a simple handshake. The block raises `vecAdv` during the clock in which the vector inputs are sampled, and it marks the first clock of every cycle with `cycStart`. Cycle definitions are loaded through a one-cycle write port while the generator is stopped. The block rejects and flags any write that is malformed or that arrives while the generator is running.

Top module: `pin_timing_fmt`

## Requirements
- R1: With divider value D on `divCount`, every timing unit lasts D+1 clocks, so a cycle of length L lasts L*(D+1) clocks. `divCount` is changed only while the generator is stopped.
- R2: `cycStart` is high during the first clock of each cycle and only then. `vecAdv` is high while `run` is high, in each clock where the generator is stopped and in the last clock of each cycle. The vector inputs are sampled at the clock edge that ends that clock.
- R3: A write with `cfgWe` high while stopped, with a length of at least 4 and all eight event offsets below the length, stores the length and the offsets into definition `cfgSel`. Event k is `cfgOffs[8k+7:8k]`. A cycle then uses the length and the offsets of the definition named by `vecSet`.
- R4: A write with a length below 4, or with any event offset greater than or equal to the length, raises `cfgErr` for the one clock after the write and leaves the definition unchanged.
- R5: A write made while the generator is running is ignored and raises `cfgErr` for the one clock after the write.
- R6: Format code 0 (non-return), and the unused codes 5 to 7, drive the previous pin level before the drive-start unit and the new data from that unit to the end of the cycle, with drive enabled for the whole cycle.
- R7: Format code 1 (return-to-zero) drives the data inside the drive span and 0 outside it. Format code 2 (return-to-one) drives the data inside the span and 1 outside it. The span is the units u with start <= u < end.
- R8: Format code 3 (surround-by-complement) drives the data inside the drive span and its complement outside it.
- R9: Format code 4 (return-to-high-impedance) raises drive enable only inside the drive span, with the level equal to the data.
- R10: `cmpWin` is high for the units u with window-open offset <= u < window-close offset.
- R11: When `run` is low at the end of a cycle, the generator stops: no `vecAdv` and no `cycStart`, with drive enable and the compare window low.
- R12: After reset the generator is stopped and drive enable, `cmpWin`, `cycStart` and `cfgErr` are low. Every definition holds length 4 with all offsets 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start the generator, or keep it running |
| divCount | input | 16 | Prescaler value D; one unit is D+1 clocks |
| cfgWe | input | 1 | Cycle-definition write strobe |
| cfgSel | input | 3 | Definition number to write |
| cfgLen | input | 8 | Cycle length in units |
| cfgOffs | input | 64 | Eight event offsets, event k in bits 8k+7:8k |
| cfgErr | output | 1 | Write rejected, one clock pulse |
| vecSet | input | 3 | Definition used by the next cycle |
| vecData | input | 1 | Drive data bit of the next vector |
| vecFmt | input | 3 | Format code of the next vector |
| drvOnSel | input | 3 | Event that starts the drive span |
| drvOffSel | input | 3 | Event that ends the drive span |
| cmpOnSel | input | 3 | Event that opens the compare window |
| cmpOffSel | input | 3 | Event that closes the compare window |
| vecAdv | output | 1 | Vector inputs sampled at the end of this clock |
| cycStart | output | 1 | First clock of a cycle |
| drvLevel | output | 1 | Pin drive level |
| drvEn | output | 1 | Pin drive enable |
| cmpWin | output | 1 | Compare-strobe window |

## Verification
The assertions check the handshake on every clock. A sampled vector must be followed by a cycle start, a cycle start never coincides with a sample clock, and `vecAdv` needs `run`. They also check that a stopped generator keeps the pin released with the window closed, and that `cfgErr` only follows a write and always follows a write made while running. The waveform content cannot be seen from a property alone: the shape of each format, where the edges fall for a given event selection, the unit stretching by the prescaler, and the fact that a rejected definition stays unchanged. The directed scenarios show these by comparing every clock of each cycle with levels worked out from the requirements.

// File: rtl/pinfmt_pkg.sv
package pinfmt_pkg;
  localparam int UNIT_W = 8;

  localparam logic [2:0] FMT_NR  = 3'd0;
  localparam logic [2:0] FMT_RZ  = 3'd1;
  localparam logic [2:0] FMT_RO  = 3'd2;
  localparam logic [2:0] FMT_SBC = 3'd3;
  localparam logic [2:0] FMT_ZD  = 3'd4;

  // control -> waveform datapath
  typedef struct packed {
    logic              load;    // vector captured at this edge
    logic              active;  // generator running
    logic [UNIT_W-1:0] unit;    // current unit inside the cycle
  } ctlStrobe_t;
endpackage

// File: rtl/pft_ctrl.sv
module pft_ctrl
  import pinfmt_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int NUM_SETS = 8,
  parameter int NUM_EV   = 8,
  parameter int MIN_LEN  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic [DIV_W-1:0]           divCount,
  input  logic                       cfgWe,
  input  logic [$clog2(NUM_SETS)-1:0] cfgSel,
  input  logic [UNIT_W-1:0]          cfgLen,
  input  logic [NUM_EV*UNIT_W-1:0]   cfgOffs,
  input  logic [$clog2(NUM_SETS)-1:0] vecSet,
  output ctlStrobe_t                 strobe,
  output logic [NUM_EV*UNIT_W-1:0]   selOffs,
  output logic                       vecAdv,
  output logic                       cycStart,
  output logic                       cfgErr
);
  localparam int OFFS_W = NUM_EV * UNIT_W;

  logic [UNIT_W-1:0] defLen  [NUM_SETS];
  logic [OFFS_W-1:0] defOffs [NUM_SETS];

  logic              running;
  logic [DIV_W-1:0]  preCnt;
  logic [UNIT_W-1:0] unitCnt;
  logic [UNIT_W-1:0] curLen;
  logic [NUM_EV-1:0] evOk;
  logic              cfgValid, cfgAccept, tick, lastClk;

  for (genvar k = 0; k < NUM_EV; k++) begin : g_evchk
    assign evOk[k] = cfgOffs[k*UNIT_W +: UNIT_W] < cfgLen;
  end

  assign cfgValid  = (cfgLen >= UNIT_W'(MIN_LEN)) && (&evOk);
  assign cfgAccept = cfgWe && !running && cfgValid;

  assign tick    = preCnt >= divCount;
  assign lastClk = running && tick && (unitCnt == curLen - UNIT_W'(1));
  assign vecAdv  = run && (!running || lastClk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SETS; i++) begin
        defLen[i]  <= UNIT_W'(MIN_LEN);
        defOffs[i] <= '0;
      end
      cfgErr <= 1'b0;
    end else begin
      if (cfgAccept) begin
        defLen[cfgSel]  <= cfgLen;
        defOffs[cfgSel] <= cfgOffs;
      end
      cfgErr <= cfgWe && !cfgAccept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      preCnt   <= '0;
      unitCnt  <= '0;
      curLen   <= UNIT_W'(MIN_LEN);
      cycStart <= 1'b0;
    end else begin
      cycStart <= vecAdv;
      if (vecAdv) begin
        running <= 1'b1;
        preCnt  <= '0;
        unitCnt <= '0;
        curLen  <= defLen[vecSet];
      end else if (lastClk) begin
        running <= 1'b0;
      end else if (running) begin
        if (tick) begin
          preCnt  <= '0;
          unitCnt <= unitCnt + UNIT_W'(1);
        end else begin
          preCnt <= preCnt + DIV_W'(1);
        end
      end
    end
  end

  assign selOffs       = defOffs[vecSet];
  assign strobe.load   = vecAdv;
  assign strobe.active = running;
  assign strobe.unit   = unitCnt;
endmodule

// File: rtl/pft_wave.sv
module pft_wave
  import pinfmt_pkg::*;
#(
  parameter int NUM_EV = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctlStrobe_t                    strobe,
  input  logic [NUM_EV*UNIT_W-1:0]      selOffs,
  input  logic                          vecData,
  input  logic [2:0]                    vecFmt,
  input  logic [$clog2(NUM_EV)-1:0]     drvOnSel,
  input  logic [$clog2(NUM_EV)-1:0]     drvOffSel,
  input  logic [$clog2(NUM_EV)-1:0]     cmpOnSel,
  input  logic [$clog2(NUM_EV)-1:0]     cmpOffSel,
  output logic                          drvLevel,
  output logic                          drvEn,
  output logic                          cmpWin
);
  logic [UNIT_W-1:0] onPos, offPos, winOnPos, winOffPos;
  logic              dataBit, heldLvl;
  logic [2:0]        fmtCur;
  logic              inSpan, started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onPos     <= '0;
      offPos    <= '0;
      winOnPos  <= '0;
      winOffPos <= '0;
      dataBit   <= 1'b0;
      heldLvl   <= 1'b0;
      fmtCur    <= FMT_NR;
    end else if (strobe.load) begin
      onPos     <= selOffs[drvOnSel*UNIT_W +: UNIT_W];
      offPos    <= selOffs[drvOffSel*UNIT_W +: UNIT_W];
      winOnPos  <= selOffs[cmpOnSel*UNIT_W +: UNIT_W];
      winOffPos <= selOffs[cmpOffSel*UNIT_W +: UNIT_W];
      dataBit   <= vecData;
      fmtCur    <= vecFmt;
      heldLvl   <= drvLevel;
    end
  end

  assign started = strobe.unit >= onPos;
  assign inSpan  = started && (strobe.unit < offPos);
  assign cmpWin  = strobe.active && (strobe.unit >= winOnPos) && (strobe.unit < winOffPos);

  always_comb begin
    drvLevel = heldLvl;
    drvEn    = 1'b0;
    if (strobe.active) begin
      drvEn = 1'b1;
      case (fmtCur)
        FMT_RZ:  drvLevel = inSpan ? dataBit : 1'b0;
        FMT_RO:  drvLevel = inSpan ? dataBit : 1'b1;
        FMT_SBC: drvLevel = inSpan ? dataBit : ~dataBit;
        FMT_ZD: begin
          drvLevel = dataBit;
          drvEn    = inSpan;
        end
        default: drvLevel = started ? dataBit : heldLvl;
      endcase
    end
  end
endmodule

// File: rtl/pin_timing_fmt.sv
module pin_timing_fmt
  import pinfmt_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int NUM_SETS = 8,
  parameter int NUM_EV   = 8,
  parameter int MIN_LEN  = 4,
  localparam int SEL_W   = $clog2(NUM_SETS),
  localparam int EV_W    = $clog2(NUM_EV),
  localparam int OFFS_W  = NUM_EV * UNIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  divCount,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [UNIT_W-1:0] cfgLen,
  input  logic [OFFS_W-1:0] cfgOffs,
  output logic              cfgErr,
  input  logic [SEL_W-1:0]  vecSet,
  input  logic              vecData,
  input  logic [2:0]        vecFmt,
  input  logic [EV_W-1:0]   drvOnSel,
  input  logic [EV_W-1:0]   drvOffSel,
  input  logic [EV_W-1:0]   cmpOnSel,
  input  logic [EV_W-1:0]   cmpOffSel,
  output logic              vecAdv,
  output logic              cycStart,
  output logic              drvLevel,
  output logic              drvEn,
  output logic              cmpWin
);
  ctlStrobe_t        ctlStb;
  logic [OFFS_W-1:0] selOffs;

  pft_ctrl #(
    .DIV_W(DIV_W), .NUM_SETS(NUM_SETS), .NUM_EV(NUM_EV), .MIN_LEN(MIN_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .divCount(divCount),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgLen(cfgLen), .cfgOffs(cfgOffs),
    .vecSet(vecSet), .strobe(ctlStb), .selOffs(selOffs),
    .vecAdv(vecAdv), .cycStart(cycStart), .cfgErr(cfgErr)
  );

  pft_wave #(.NUM_EV(NUM_EV)) u_wave (
    .clk(clk), .rst_n(rst_n), .strobe(ctlStb), .selOffs(selOffs),
    .vecData(vecData), .vecFmt(vecFmt),
    .drvOnSel(drvOnSel), .drvOffSel(drvOffSel),
    .cmpOnSel(cmpOnSel), .cmpOffSel(cmpOffSel),
    .drvLevel(drvLevel), .drvEn(drvEn), .cmpWin(cmpWin)
  );
endmodule

// File: rtl/pft_checker.sv
module pft_checker (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic running,
  input logic cfgWe,
  input logic cfgErr,
  input logic vecAdv,
  input logic cycStart,
  input logic drvEn,
  input logic cmpWin
);
  p_adv_then_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vecAdv |=> cycStart);

  p_start_not_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycStart |-> (!vecAdv && running));

  p_adv_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vecAdv |-> run);

  p_err_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfgErr |-> $past(cfgWe));

  p_busy_write_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWe && running) |=> cfgErr);

  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!drvEn && !cmpWin && !cycStart));
endmodule

bind pin_timing_fmt pft_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .running(ctlStb.active),
  .cfgWe(cfgWe), .cfgErr(cfgErr), .vecAdv(vecAdv), .cycStart(cycStart),
  .drvEn(drvEn), .cmpWin(cmpWin)
);

// File: tb/sim_pin_timing_fmt.sv
module sim_pin_timing_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] divCount = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [7:0]  cfgLen = '0;
  logic [63:0] cfgOffs = '0;
  logic        cfgErr;
  logic [2:0]  vecSet = '0;
  logic        vecData = 1'b0;
  logic [2:0]  vecFmt = '0;
  logic [2:0]  drvOnSel = '0, drvOffSel = '0, cmpOnSel = '0, cmpOffSel = '0;
  logic        vecAdv, cycStart, drvLevel, drvEn, cmpWin;

  int nChk = 0;
  int nBad = 0;
  logic [7:0] mLen [8];
  logic [7:0] mOff [8][8];
  logic       prevLvl = 1'b0;

  always #4 clk = ~clk;

  pin_timing_fmt u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .divCount(divCount),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgLen(cfgLen), .cfgOffs(cfgOffs),
    .cfgErr(cfgErr), .vecSet(vecSet), .vecData(vecData), .vecFmt(vecFmt),
    .drvOnSel(drvOnSel), .drvOffSel(drvOffSel), .cmpOnSel(cmpOnSel),
    .cmpOffSel(cmpOffSel), .vecAdv(vecAdv), .cycStart(cycStart),
    .drvLevel(drvLevel), .drvEn(drvEn), .cmpWin(cmpWin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [63:0] packOffs(input logic [7:0] o [8]);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = o[k];
    return r;
  endfunction

  // one definition write; expects acceptance unless expErr
  task automatic writeDef(input logic [2:0] s, input logic [7:0] len,
                          input logic [7:0] o [8], input logic expErr, input string tag);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = s; cfgLen = len; cfgOffs = packOffs(o);
    @(negedge clk);
    chk(tag, cfgErr, expErr);
    cfgWe = 1'b0;
    if (!expErr) begin
      mLen[s] = len;
      for (int k = 0; k < 8; k++) mOff[s][k] = o[k];
    end
  endtask

  // one full cycle compared clock by clock
  task automatic runCycle(input logic [2:0] s, input logic [2:0] fmt, input logic d,
                          input logic [2:0] eOn, input logic [2:0] eOff,
                          input logic [2:0] wOn, input logic [2:0] wOff,
                          input logic stopAfter, input logic poke, input string tag);
    int per = int'(divCount) + 1;
    int total = int'(mLen[s]) * per;
    logic [7:0] pOn = mOff[s][eOn], pOff = mOff[s][eOff];
    logic [7:0] qOn = mOff[s][wOn], qOff = mOff[s][wOff];
    logic held = prevLvl;
    #1;
    chk({tag, " R2 adv before cycle"}, vecAdv, 1'b1);
    vecSet = s; vecFmt = fmt; vecData = d;
    drvOnSel = eOn; drvOffSel = eOff; cmpOnSel = wOn; cmpOffSel = wOff;
    for (int t = 0; t < total; t++) begin
      int u;
      logic span, eLvl, eEn, eWin;
      @(negedge clk);
      u = t / per;
      span = (u >= int'(pOn)) && (u < int'(pOff));
      eWin = (u >= int'(qOn)) && (u < int'(qOff));
      eEn = 1'b1;
      case (fmt)
        3'd1: eLvl = span ? d : 1'b0;
        3'd2: eLvl = span ? d : 1'b1;
        3'd3: eLvl = span ? d : ~d;
        3'd4: begin eLvl = d; eEn = span; end
        default: eLvl = (u >= int'(pOn)) ? d : held;
      endcase
      chk({tag, " R1 R2 cycStart"}, cycStart, t == 0);
      chk({tag, " R1 R2 vecAdv"}, vecAdv, (t == total - 1) ? run : 1'b0);
      chk({tag, " R10 cmpWin"}, cmpWin, eWin);
      chk({tag, " R9 drvEn"}, drvEn, eEn);
      if (eEn) chk({tag, " R6 R7 R8 drvLevel"}, drvLevel, eLvl);
      prevLvl = eLvl;
      if (t == 0 && stopAfter) run = 1'b0;
      if (poke && t == 1) begin
        cfgWe = 1'b1; cfgSel = 3'd0; cfgLen = 8'd5; cfgOffs = '0;
      end
      if (poke && t == 2) begin
        chk({tag, " R5 busy write flagged"}, cfgErr, 1'b1);
        cfgWe = 1'b0;
      end
    end
    if (stopAfter) begin
      @(negedge clk);
      chk({tag, " R11 stopped drvEn"}, drvEn, 1'b0);
      chk({tag, " R11 stopped cmpWin"}, cmpWin, 1'b0);
      chk({tag, " R11 stopped cycStart"}, cycStart, 1'b0);
      chk({tag, " R11 stopped vecAdv"}, vecAdv, 1'b0);
    end
  endtask

  task automatic testReset();
    chk("R12 reset drvEn", drvEn, 1'b0);
    chk("R12 reset cmpWin", cmpWin, 1'b0);
    chk("R12 reset cycStart", cycStart, 1'b0);
    chk("R12 reset cfgErr", cfgErr, 1'b0);
    chk("R12 reset vecAdv", vecAdv, 1'b0);
  endtask

  task automatic testConfig();
    logic [7:0] o0 [8] = '{8'd0, 8'd2, 8'd5, 8'd1, 8'd6, 8'd7, 8'd3, 8'd4};
    logic [7:0] o1 [8] = '{8'd0, 8'd3, 8'd9, 8'd2, 8'd10, 8'd11, 8'd1, 8'd4};
    logic [7:0] o2 [8] = '{8'd0, 8'd1, 8'd3, 8'd2, 8'd0, 8'd0, 8'd0, 8'd0};
    logic [7:0] zz [8] = '{default: 8'd0};
    for (int s = 0; s < 8; s++) begin
      mLen[s] = 8'd4;
      for (int k = 0; k < 8; k++) mOff[s][k] = 8'd0;
    end
    writeDef(3'd0, 8'd8, o0, 1'b0, "R3 write set0 accepted");
    writeDef(3'd1, 8'd12, o1, 1'b0, "R3 write set1 accepted");
    writeDef(3'd2, 8'd4, o2, 1'b0, "R3 write set2 min length accepted");
    writeDef(3'd3, 8'd3, zz, 1'b1, "R4 short length rejected");
    writeDef(3'd1, 8'd6, o1, 1'b1, "R4 offset beyond length rejected");
  endtask

  task automatic testFormats();
    run = 1'b1;
    runCycle(3'd0, 3'd0, 1'b1, 3'd1, 3'd2, 3'd3, 3'd4, 1'b0, 1'b0, "R6 NR set0");
    runCycle(3'd0, 3'd1, 1'b1, 3'd1, 3'd2, 3'd3, 3'd4, 1'b0, 1'b0, "R7 RZ set0");
    runCycle(3'd0, 3'd2, 1'b0, 3'd1, 3'd2, 3'd3, 3'd4, 1'b0, 1'b0, "R7 RO set0");
    // set1 still 12 units long: the rejected write did not apply (R4)
    runCycle(3'd1, 3'd3, 1'b1, 3'd1, 3'd2, 3'd6, 3'd7, 1'b0, 1'b1, "R8 SBC set1 R4");
    runCycle(3'd1, 3'd4, 1'b0, 3'd1, 3'd2, 3'd6, 3'd7, 1'b1, 1'b0, "R9 ZD set1 stop");
  endtask

  task automatic testPrescale();
    divCount = 16'd2;
    @(negedge clk);
    run = 1'b1;
    runCycle(3'd2, 3'd0, 1'b1, 3'd1, 3'd2, 3'd3, 3'd2, 1'b0, 1'b0, "R1 NR set2 div2");
    // set0 keeps length 8 after the busy write (R5); code 6 acts as NR
    runCycle(3'd0, 3'd6, 1'b0, 3'd3, 3'd2, 3'd0, 3'd1, 1'b1, 1'b0, "R5 R6 code6 set0");
  endtask

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog R2: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testFormats();
    testPrescale();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule